// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Register Block

This block turns receive-side DS3 alarm indications into byte-wide registers that a microprocessor reads, and into one interrupt line. A receive framer, outside this block, supplies the out-of-frame level, the idle-pattern level, the two X-bits and the AIC bit together with a once-per-M-frame valid strobe, and single-cycle P-bit parity error pulses.

The block keeps a current-state copy of each condition. It derives the far-end receive failure (FERF) state from the X-bit pair. Any change of state, in either direction, is latched as an event in an interrupt status register, and that register clears when it is read. An enable register gates each status bit onto the interrupt output. A two-bit control register for the framer's synchronisation options is also held here.

Top module: `ds3_rx_alarm_regs`

## Requirements
- R1: After reset every register reads 0, `rdata_o` is 0 and `irq_o` is 0.
- R2: The OOF change bit (status bit 1) and the idle-pattern change bit (status bit 4) are set one cycle after `oof_i` or `idle_i` differs from the stored state. This applies both when the condition rises and when it falls.
- R3: On `frame_valid_i`, X-bits `2'b00` declare FERF, `2'b11` remove it, and `2'b01` or `2'b10` leave it unchanged. Each FERF state change sets the FERF change bit (status bit 3).
- R4: On `frame_valid_i`, an `aic_i` value that differs from the stored AIC value sets the AIC change bit (status bit 2). `aic_i` is ignored when `frame_valid_i` is low.
- R5: Any `perr_i` pulse sets the P-bit error bit (status bit 0).
- R6: A read takes effect on the clock edge where `rd_i` is high, and `rdata_o` holds the value from then on. A read of the status register at 0x13 returns its contents and clears it, so a bit reads 1 only if its event occurred since the previous read.
- R7: An event in the same cycle as a clearing read of 0x13 stays set and appears on the next read.
- R8: Address 0x10 returns idle state in bit 5 and OOF state in bit 4. Address 0x11 returns FERF state in bit 4 and AIC state in bit 3. All other bits, and unmapped addresses, read 0.
- R9: Bits 1:0 at address 0x14 are read/write. Bits 7:2 read 0, and writes to them are ignored.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit is set in register 0x12 (bits 4:0, same layout as the status register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | M-frame strobe qualifying the X-bits and AIC |
| xbits_i | input | 2 | Received X-bit pair |
| aic_i | input | 1 | Received AIC bit |
| oof_i | input | 1 | Out-of-frame level from the framer |
| idle_i | input | 1 | Idle-pattern detected level |
| perr_i | input | 1 | P-bit parity error pulse |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench exercises the falling edge of each level condition. A design that latches only the onset would miss the clearing of OOF, idle and FERF. It drives the disagreeing X-bit codes, which a design that decodes only one bit would take as FERF entry or exit, and it changes AIC off-strobe, which must not raise an event. It places a parity pulse in the same cycle as a clearing read: a design that lets the clear win would lose that error. It also writes all ones to the control register, so a design that stores the read-only bits would return them.

// File: rtl/ds3_alarm_pkg.sv
package ds3_alarm_pkg;
  localparam int NEVT = 5;
  localparam logic [7:0] A_CFG  = 8'h10;
  localparam logic [7:0] A_STAT = 8'h11;
  localparam logic [7:0] A_IEN  = 8'h12;
  localparam logic [7:0] A_ISR  = 8'h13;
  localparam logic [7:0] A_SYNC = 8'h14;
  localparam int B_PERR = 0;
  localparam int B_OOF  = 1;
  localparam int B_AIC  = 2;
  localparam int B_FERF = 3;
  localparam int B_IDLE = 4;

  typedef struct packed {
    logic idle;
    logic ferf;
    logic aic;
    logic oof;
  } cond_t;
endpackage

// File: rtl/ds3_cond_track.sv
module ds3_cond_track
  import ds3_alarm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_valid_i,
  input  logic [1:0]      xbits_i,
  input  logic            aic_i,
  input  logic            oof_i,
  input  logic            idle_i,
  input  logic            perr_i,
  output cond_t           st_o,
  output logic [NEVT-1:0] evt_o
);
  cond_t st_q, st_d;

  // R3: disagreeing X-bits keep the FERF state
  always_comb begin
    st_d      = st_q;
    st_d.oof  = oof_i;
    st_d.idle = idle_i;
    if (frame_valid_i) begin
      st_d.aic = aic_i;
      if (xbits_i == 2'b00)      st_d.ferf = 1'b1;
      else if (xbits_i == 2'b11) st_d.ferf = 1'b0;
    end
  end

  always_comb begin
    evt_o         = '0;
    evt_o[B_PERR] = perr_i;
    evt_o[B_OOF]  = st_d.oof  ^ st_q.oof;
    evt_o[B_AIC]  = st_d.aic  ^ st_q.aic;
    evt_o[B_FERF] = st_d.ferf ^ st_q.ferf;
    evt_o[B_IDLE] = st_d.idle ^ st_q.idle;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;

  assign st_o = st_q;
endmodule

// File: rtl/ds3_irq_status.sv
module ds3_irq_status #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  // R7: a new event wins over the clearing read
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) sts_q[i] <= 1'b0;
      else         sts_q[i] <= (sts_q[i] & ~clr_i) | evt_i[i];
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/ds3_reg_file.sv
module ds3_reg_file
  import ds3_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  cond_t             st_i,
  input  logic [NEVT-1:0]   sts_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NEVT-1:0]   ien_o,
  output logic              isr_clr_o
);
  logic [NEVT-1:0]   ien_q;
  logic [SYNC_W-1:0] sync_q;
  logic [DATA_W-1:0] rmux, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ien_q  <= '0;
      sync_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(A_IEN))  ien_q  <= wdata_i[NEVT-1:0];
      if (addr_i == ADDR_W'(A_SYNC)) sync_q <= wdata_i[SYNC_W-1:0];  // R9
    end

  // R8: state bit positions
  always_comb begin
    rmux = '0;
    unique case (addr_i)
      ADDR_W'(A_CFG):  begin rmux[5] = st_i.idle; rmux[4] = st_i.oof; end
      ADDR_W'(A_STAT): begin rmux[4] = st_i.ferf; rmux[3] = st_i.aic; end
      ADDR_W'(A_IEN):  rmux[NEVT-1:0] = ien_q;
      ADDR_W'(A_ISR):  rmux[NEVT-1:0] = sts_i;
      ADDR_W'(A_SYNC): rmux[SYNC_W-1:0] = sync_q;
      default:         rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;

  assign isr_clr_o = rd_i && (addr_i == ADDR_W'(A_ISR));
  assign rdata_o   = rdata_q;
  assign ien_o     = ien_q;
endmodule

// File: rtl/ds3_rx_alarm_regs.sv
module ds3_rx_alarm_regs
  import ds3_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [1:0]        xbits_i,
  input  logic              aic_i,
  input  logic              oof_i,
  input  logic              idle_i,
  input  logic              perr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  cond_t           st;
  logic [NEVT-1:0] evt, sts, ien;
  logic            isr_clr;

  ds3_cond_track u_track (
    .clk_i, .rst_ni, .frame_valid_i, .xbits_i, .aic_i, .oof_i, .idle_i,
    .perr_i, .st_o(st), .evt_o(evt)
  );

  ds3_irq_status #(.N(NEVT)) u_sts (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(isr_clr), .sts_o(sts)
  );

  ds3_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .st_i(st), .sts_i(sts),
    .rdata_o, .ien_o(ien), .isr_clr_o(isr_clr)
  );

  assign irq_o = |(sts & ien);  // R10
endmodule

// File: rtl/ds3_rx_alarm_regs_chk.sv
module ds3_rx_alarm_regs_chk
  import ds3_alarm_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_valid_i,
  input logic [1:0]      xbits_i,
  input logic            oof_i,
  input logic            idle_i,
  input logic            perr_i,
  input logic [7:0]      addr_i,
  input logic            rd_i,
  input logic [7:0]      rdata_o,
  input logic            irq_o,
  input cond_t           st,
  input logic [NEVT-1:0] evt,
  input logic [NEVT-1:0] sts
);
  p_oof_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oof_i != st.oof) |=> sts[B_OOF]);
  p_idle_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i != st.idle) |=> sts[B_IDLE]);
  p_ferf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && xbits_i == 2'b00) |=> st.ferf);
  p_ferf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && (xbits_i == 2'b01 || xbits_i == 2'b10)) |=> $stable(st.ferf));
  p_perr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_i |=> sts[B_PERR]);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_ISR && evt == '0) |=> (sts == '0));
  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));
  p_sync_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_SYNC) |=> (rdata_o[7:2] == 6'd0));
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_ISR && evt == '0) |=> !irq_o);
endmodule

bind ds3_rx_alarm_regs ds3_rx_alarm_regs_chk u_chk (
  .clk_i, .rst_ni, .frame_valid_i, .xbits_i, .oof_i, .idle_i, .perr_i,
  .addr_i, .rd_i, .rdata_o, .irq_o, .st, .evt, .sts
);

// File: tb/ds3_rx_alarm_regs_tb.sv
module ds3_rx_alarm_regs_tb;
  logic clk = 0, rst_ni = 0;
  logic frame_valid = 0, aic = 0, oof = 0, idle = 0, perr = 0, wr = 0, rd = 0;
  logic [1:0] xbits = 2'b11;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic irq;
  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ds3_rx_alarm_regs u_dut (
    .clk_i(clk), .rst_ni, .frame_valid_i(frame_valid), .xbits_i(xbits),
    .aic_i(aic), .oof_i(oof), .idle_i(idle), .perr_i(perr), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit m_oof, m_idle, m_aic, m_ferf;
  bit [4:0] m_sts, m_ien;
  bit [1:0] m_sync;
  bit [7:0] m_rdata;

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'h10: return {2'b00, m_idle, m_oof, 4'h0};
      8'h11: return {3'b000, m_ferf, m_aic, 3'b000};
      8'h12: return {3'b000, m_ien};
      8'h13: return {3'b000, m_sts};
      8'h14: return {6'd0, m_sync};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_oof = 0; m_idle = 0; m_aic = 0; m_ferf = 0;
      m_sts = 0; m_ien = 0; m_sync = 0; m_rdata = 0;
    end else begin
      bit [4:0] ev;
      bit nf, na;
      nf = m_ferf; na = m_aic;
      if (frame_valid) begin
        na = aic;
        if (xbits == 2'b00) nf = 1;
        if (xbits == 2'b11) nf = 0;
      end
      ev = {idle != m_idle, nf != m_ferf, na != m_aic, oof != m_oof, perr};
      if (rd) m_rdata = m_read(addr);
      if (rd && addr == 8'h13) m_sts = 0;
      m_sts = m_sts | ev;
      if (wr && addr == 8'h12) m_ien = wdata[4:0];
      if (wr && addr == 8'h14) m_sync = wdata[1:0];
      m_oof = oof; m_idle = idle; m_aic = na; m_ferf = nf;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // compare with model on every clock
  always @(negedge clk) if (rst_ni && !done) begin
    chk({cur_req, " model rdata"}, rdata, m_rdata);
    chk({cur_req, " model irq"}, irq, |(m_sts & m_ien));
  end

  task automatic rd_chk(input bit [7:0] a, input bit [7:0] exp, input string req);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
    chk(req, rdata, exp);
  endtask

  task automatic wr_reg(input bit [7:0] a, input bit [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic frame(input bit [1:0] x, input bit a);
    @(negedge clk); xbits = x; aic = a; frame_valid = 1;
    @(negedge clk); frame_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 0);
    chk("R1 irq in reset", irq, 0);
    rst_ni = 1;
    @(negedge clk);
    cur_req = "R1";
    rd_chk(8'h10, 8'h00, "R1 cfg");
    rd_chk(8'h11, 8'h00, "R1 stat");
    rd_chk(8'h12, 8'h00, "R1 ien");
    rd_chk(8'h13, 8'h00, "R1 isr");
    rd_chk(8'h14, 8'h00, "R1 sync");

    cur_req = "R2";
    @(negedge clk); oof = 1; @(negedge clk);
    rd_chk(8'h13, 8'h02, "R2 oof onset");
    rd_chk(8'h10, 8'h10, "R8 oof state");
    oof = 0; @(negedge clk);
    rd_chk(8'h13, 8'h02, "R2 oof cleared");
    rd_chk(8'h13, 8'h00, "R6 cleared by read");
    idle = 1; @(negedge clk);
    rd_chk(8'h13, 8'h10, "R2 idle onset");
    rd_chk(8'h10, 8'h20, "R8 idle state");
    idle = 0; @(negedge clk);
    rd_chk(8'h13, 8'h10, "R2 idle cleared");

    cur_req = "R3";
    frame(2'b00, 0);
    rd_chk(8'h13, 8'h08, "R3 ferf declared");
    rd_chk(8'h11, 8'h10, "R8 ferf state");
    frame(2'b01, 0);
    frame(2'b10, 0);
    rd_chk(8'h13, 8'h00, "R3 mixed xbits no event");
    rd_chk(8'h11, 8'h10, "R3 ferf held");
    frame(2'b11, 0);
    rd_chk(8'h13, 8'h08, "R3 ferf removed");
    rd_chk(8'h11, 8'h00, "R3 ferf state off");

    cur_req = "R4";
    frame(2'b11, 1);
    rd_chk(8'h13, 8'h04, "R4 aic change");
    rd_chk(8'h11, 8'h08, "R8 aic state");
    frame(2'b11, 1);
    @(negedge clk); aic = 0; @(negedge clk); @(negedge clk);
    rd_chk(8'h13, 8'h00, "R4 aic same or unstrobed");
    rd_chk(8'h11, 8'h08, "R4 aic held off-strobe");

    cur_req = "R5";
    @(negedge clk); perr = 1; @(negedge clk); perr = 0;
    @(negedge clk); perr = 1; @(negedge clk); perr = 0;
    rd_chk(8'h13, 8'h01, "R5 perr");

    cur_req = "R7";
    @(negedge clk); addr = 8'h13; rd = 1; perr = 1;
    @(negedge clk); rd = 0; perr = 0;
    chk("R7 read during event", rdata, 8'h00);
    rd_chk(8'h13, 8'h01, "R7 event kept");

    cur_req = "R9";
    wr_reg(8'h14, 8'hFF);
    rd_chk(8'h14, 8'h03, "R9 sync rw");
    wr_reg(8'h14, 8'h02);
    rd_chk(8'h14, 8'h02, "R9 sync bit1");
    rd_chk(8'h20, 8'h00, "R8 unmapped");

    cur_req = "R10";
    wr_reg(8'h12, 8'h02);
    rd_chk(8'h12, 8'h02, "R10 ien");
    @(negedge clk); perr = 1; @(negedge clk); perr = 0; @(negedge clk);
    chk("R10 masked irq", irq, 0);
    oof = 1; @(negedge clk);
    chk("R10 irq on enabled bit", irq, 1);
    rd_chk(8'h13, 8'h03, "R10 isr both");
    chk("R10 irq after clear", irq, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule